// File: doc/BRIEF.md
# Truth-Table Branch Resolver

This block resolves one branch per cycle for an instruction sequencer. It takes a branch word in either the short 16-bit form or the long 48-bit form, the address of the current bundle, and four 1-bit conditions. The conditions arrive as two 2-bit groups, each from one register component. From these it produces a taken flag, the next fetch address and the 4-bit tag of the destination bundle.

The branch decision is a lookup, not a fixed compare. A long word carries a 16-bit truth table, indexed by the four conditions together. A short conditional word carries a 2-bit code, which is the same table reduced to one condition. Short unconditional words and long words also carry a link mode. A call pushes the fall-through address onto a small return stack. A return pops that stack and jumps to the popped address. A push onto a full stack or a pop from an empty stack raises a one-cycle error flag. Decode and evaluation take one register stage, marked by a valid-in/valid-out pair.

Top module: `branch_lut_eval`

## Requirements
- R1: After reset, `vld_out`, `taken` and `stack_err` are 0, `next_addr` is 0 and the return stack is empty.
- R2: `vld_out` is 1 exactly one cycle after each cycle with `vld_in` high, and 0 otherwise. `taken`, `next_addr` and `dest_tag` change only one cycle after a `vld_in` cycle and hold their values in between.
- R3: In a short word (`ext_fmt`=0), op field bits [2:0] = 2 selects a conditional branch. Its code sits in bits [15:14] and acts as a 2-entry table indexed by `cond_a[0]`: taken = code[`cond_a[0]`]. So code 0 never branches, 1 branches when the condition is 0, 2 when it is 1, and 3 always. `cond_a[1]` and `cond_b` have no effect.
- R4: In a long word (`ext_fmt`=1) with op 1 or 2, taken = table[{`cond_b[1]`,`cond_b[0]`,`cond_a[1]`,`cond_a[0]`}], where the table occupies bits [47:32]. Bit 32 is entry 0.
- R5: A short word with op 1 always branches. Its 7-bit signed offset is in bits [15:9].
- R6: When a branch is taken and is not a return, `next_addr` = `pc` + the sign-extended offset. The offset is in bits [13:7] for short conditional words and in bits [31:9] (23 bits) for long words. When a branch is not taken, `next_addr` = `pc` + STEP (default 1).
- R7: `dest_tag` is bits [6:3] of the word, for every form.
- R8: Any other op value (0, 3, 4, 5, 6, 7 short; anything but 1 or 2 long) is not taken, gives the fall-through address, and leaves the return stack unchanged whatever its link bits hold.
- R9: The link mode is in bits [8:7] of short op-1 words and long words: 0 or 1 = plain, 2 = call, 3 = return. A taken call pushes `pc`+STEP and branches to the target. A call that is not taken pushes nothing.
- R10: A taken return pops the most recent pushed address, in last-in first-out order, and uses it as `next_addr`.
- R11: With RS_DEPTH (default 4) entries held, a taken call raises `stack_err` for that result, branches to the target and leaves the stack unchanged. A taken return on an empty stack raises `stack_err` and uses `pc` + offset as `next_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| vld_in | input | 1 | A branch word is presented this cycle |
| ext_fmt | input | 1 | 1 = 48-bit long form, 0 = 16-bit short form in bits [15:0] |
| br_word | input | 48 | Branch word |
| cond_a | input | 2 | Conditions C1:C0 from the first register component |
| cond_b | input | 2 | Conditions C3:C2 from the second register component |
| pc | input | ADDR_W | Address of the current bundle |
| vld_out | output | 1 | Result valid |
| taken | output | 1 | Branch taken |
| next_addr | output | ADDR_W | Next fetch address |
| dest_tag | output | 4 | Tag of the destination bundle |
| stack_err | output | 1 | Return stack overflow or underflow on this result |

## Verification
Each result, including `stack_err` and any change to the return stack, is due on the rising edge right after the `vld_in` cycle. The bench drives a word on a falling edge, drops `vld_in` on the next falling edge, and reads the outputs at that moment. This is half a period after the capturing edge and before the following edge clears `vld_out`. Return-stack effects are not visible directly, so the bench checks them through later returns: it compares the popped addresses, and the error flag, with its own last-in first-out model.

// File: rtl/bre_pkg.sv
package bre_pkg;

   localparam int WORD_W  = 48;
   localparam int TAG_W   = 4;
   localparam int OFF_W   = 23;
   localparam int TBL_W   = 16;

   localparam logic [2:0] OP_JUMP = 3'd1;
   localparam logic [2:0] OP_COND = 3'd2;

   typedef enum logic [1:0] {
      LINK_NONE  = 2'd0,
      LINK_PLAIN = 2'd1,
      LINK_CALL  = 2'd2,
      LINK_RET   = 2'd3
   } link_e;

   typedef struct packed {
      logic              hit;
      logic              taken;
      link_e             link;
      logic [OFF_W-1:0]  off;
      logic [TAG_W-1:0]  tag;
   } br_dec_t;

endpackage

// File: rtl/bre_decode.sv
module bre_decode
   import bre_pkg::*;
(
   input  logic              ext_fmt,
   input  logic [WORD_W-1:0] word,
   input  logic [1:0]        cond_a,
   input  logic [1:0]        cond_b,
   output br_dec_t           dec
);

   logic [2:0]       op;
   logic [3:0]       lut_idx;
   logic [TBL_W-1:0] table_bits;
   logic [1:0]       short_code;

   assign op         = word[2:0];
   assign lut_idx    = {cond_b, cond_a};
   assign table_bits = word[WORD_W-1 -: TBL_W];
   assign short_code = word[15:14];

   always_comb begin
      dec       = '0;
      dec.tag   = word[6:3];
      dec.link  = LINK_PLAIN;
      if (ext_fmt) begin
         dec.hit   = (op == OP_JUMP) || (op == OP_COND);
         dec.taken = dec.hit && table_bits[lut_idx];
         dec.link  = link_e'(word[8:7]);
         dec.off   = word[31:9];
      end else begin
         unique case (op)
            OP_JUMP: begin
               dec.hit   = 1'b1;
               dec.taken = 1'b1;
               dec.link  = link_e'(word[8:7]);
               dec.off   = {{(OFF_W-7){word[15]}}, word[15:9]};
            end
            OP_COND: begin
               dec.hit   = 1'b1;
               dec.taken = short_code[cond_a[0]];
               dec.off   = {{(OFF_W-7){word[13]}}, word[13:7]};
            end
            default: dec.hit = 1'b0;
         endcase
      end
   end

endmodule

// File: rtl/bre_retstack.sv
module bre_retstack #(
   parameter int W     = 32,
   parameter int DEPTH = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic         pop,
   input  logic [W-1:0] din,
   output logic [W-1:0] top,
   output logic         empty,
   output logic         full
);

   localparam int CNT_W = $clog2(DEPTH + 1);

   if (DEPTH < 1) begin : g_bad_depth
      $error("bre_retstack: DEPTH must be at least 1");
   end

   logic [CNT_W-1:0]   cnt;
   logic [DEPTH*W-1:0] flat;
   logic               do_push;
   logic               do_pop;

   assign empty   = (cnt == '0);
   assign full    = (cnt == CNT_W'(DEPTH));
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   assign top     = flat[W-1:0];

   always_ff @(posedge clk) begin
      if (!rst_n)       cnt <= '0;
      else if (do_push) cnt <= cnt + 1'b1;
      else if (do_pop)  cnt <= cnt - 1'b1;
   end

   for (genvar i = 0; i < DEPTH; i++) begin : g_ent
      logic [W-1:0] q;
      logic [W-1:0] above;
      logic [W-1:0] below;

      if (i == 0) begin : g_first
         assign above = din;
      end else begin : g_mid
         assign above = flat[(i-1)*W +: W];
      end

      if (i == DEPTH-1) begin : g_last
         assign below = '0;
      end else begin : g_inner
         assign below = flat[(i+1)*W +: W];
      end

      always_ff @(posedge clk) begin
         if (!rst_n)       q <= '0;
         else if (do_push) q <= above;
         else if (do_pop)  q <= below;
      end

      assign flat[i*W +: W] = q;
   end

   // R9
   push_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
      push && !full |=> top == $past(din));

   // R11
   overflow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      push && full |=> full && top == $past(top));

   // R11
   underflow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pop && empty |=> empty);

endmodule

// File: rtl/branch_lut_eval.sv
module branch_lut_eval
   import bre_pkg::*;
#(
   parameter int ADDR_W   = 32,
   parameter int STEP     = 1,
   parameter int RS_DEPTH = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              vld_in,
   input  logic              ext_fmt,
   input  logic [47:0]       br_word,
   input  logic [1:0]        cond_a,
   input  logic [1:0]        cond_b,
   input  logic [ADDR_W-1:0] pc,
   output logic              vld_out,
   output logic              taken,
   output logic [ADDR_W-1:0] next_addr,
   output logic [3:0]        dest_tag,
   output logic              stack_err
);

   if (ADDR_W < OFF_W) begin : g_bad_addr
      $error("branch_lut_eval: ADDR_W must hold the 23-bit offset");
   end
   if (STEP < 1) begin : g_bad_step
      $error("branch_lut_eval: STEP must be positive");
   end

   br_dec_t           dec;
   logic [ADDR_W-1:0] off_ext;
   logic [ADDR_W-1:0] target;
   logic [ADDR_W-1:0] fall;
   logic [ADDR_W-1:0] rs_top;
   logic              rs_empty;
   logic              rs_full;
   logic              is_call;
   logic              is_ret;
   logic              err_now;
   logic [ADDR_W-1:0] next_now;

   bre_decode u_dec (
      .ext_fmt (ext_fmt),
      .word    (br_word),
      .cond_a  (cond_a),
      .cond_b  (cond_b),
      .dec     (dec)
   );

   if (ADDR_W > OFF_W) begin : g_sext
      assign off_ext = {{(ADDR_W-OFF_W){dec.off[OFF_W-1]}}, dec.off};
   end else begin : g_nosext
      assign off_ext = dec.off;
   end

   assign target  = pc + off_ext;
   assign fall    = pc + ADDR_W'(STEP);
   assign is_call = vld_in && dec.taken && (dec.link == LINK_CALL);
   assign is_ret  = vld_in && dec.taken && (dec.link == LINK_RET);
   assign err_now = (is_call && rs_full) || (is_ret && rs_empty);

   always_comb begin
      if (!dec.taken)              next_now = fall;
      else if (is_ret && !rs_empty) next_now = rs_top;
      else                         next_now = target;
   end

   bre_retstack #(.W(ADDR_W), .DEPTH(RS_DEPTH)) u_rs (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (is_call),
      .pop   (is_ret),
      .din   (fall),
      .top   (rs_top),
      .empty (rs_empty),
      .full  (rs_full)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld_out   <= 1'b0;
         taken     <= 1'b0;
         next_addr <= '0;
         dest_tag  <= '0;
         stack_err <= 1'b0;
      end else begin
         vld_out   <= vld_in;
         stack_err <= vld_in && err_now;
         if (vld_in) begin
            taken     <= dec.taken;
            next_addr <= next_now;
            dest_tag  <= dec.tag;
         end
      end
   end

   // R2
   vld_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      vld_in |=> vld_out);

   // R2
   vld_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !vld_in |=> !vld_out && $stable(next_addr) && $stable(taken));

   // R3
   never_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      vld_in && !ext_fmt && br_word[2:0] == OP_COND && br_word[15:14] == 2'b00
      |=> !taken);

   // R8
   foreign_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
      vld_in && br_word[2:0] != OP_JUMP && br_word[2:0] != OP_COND
      |=> !taken && !stack_err && next_addr == $past(pc) + ADDR_W'(STEP));

   // R11
   err_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stack_err |-> vld_out && taken);

endmodule

// File: tb/tb_branch_lut_eval.sv
module tb_branch_lut_eval;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        vld_in = 1'b0;
   logic        ext_fmt = 1'b0;
   logic [47:0] br_word = '0;
   logic [1:0]  cond_a = '0;
   logic [1:0]  cond_b = '0;
   logic [31:0] pc = '0;
   logic        vld_out;
   logic        taken;
   logic [31:0] next_addr;
   logic [3:0]  dest_tag;
   logic        stack_err;

   int checks = 0;
   int failures = 0;

   always #4 clk = ~clk;

   branch_lut_eval dut (
      .clk(clk), .rst_n(rst_n), .vld_in(vld_in), .ext_fmt(ext_fmt),
      .br_word(br_word), .cond_a(cond_a), .cond_b(cond_b), .pc(pc),
      .vld_out(vld_out), .taken(taken), .next_addr(next_addr),
      .dest_tag(dest_tag), .stack_err(stack_err)
   );

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [47:0] cw(input logic [3:0] tag, input logic [6:0] off,
                                      input logic [1:0] code);
      return {32'b0, code, off, tag, 3'd2};
   endfunction

   function automatic logic [47:0] uw(input logic [3:0] tag, input logic [1:0] link,
                                      input logic [6:0] off);
      return {32'b0, off, link, tag, 3'd1};
   endfunction

   function automatic logic [47:0] xw(input logic [2:0] op, input logic [3:0] tag,
                                      input logic [1:0] link, input logic [22:0] off,
                                      input logic [15:0] tbl);
      return {tbl, off, link, tag, op};
   endfunction

   task automatic issue(input logic ext, input logic [47:0] w, input logic [1:0] a,
                        input logic [1:0] b, input logic [31:0] p);
      @(negedge clk);
      vld_in = 1'b1; ext_fmt = ext; br_word = w; cond_a = a; cond_b = b; pc = p;
      @(negedge clk);
      vld_in = 1'b0; br_word = '0; pc = 32'hDEAD_0000;
   endtask

   task automatic expect_res(input string req, input logic t, input logic [31:0] n,
                             input logic [3:0] tg, input logic e);
      chk({req, " vld_out"}, 64'(vld_out), 64'(1'b1));
      chk({req, " taken"}, 64'(taken), 64'(t));
      chk({req, " next_addr"}, 64'(next_addr), 64'(n));
      chk({req, " dest_tag"}, 64'(dest_tag), 64'(tg));
      chk({req, " stack_err"}, 64'(stack_err), 64'(e));
   endtask

   task automatic t_reset();
      // R1
      chk("R1 vld_out", 64'(vld_out), 0);
      chk("R1 taken", 64'(taken), 0);
      chk("R1 next_addr", 64'(next_addr), 0);
      chk("R1 stack_err", 64'(stack_err), 0);
   endtask

   task automatic t_short_cond();
      // R3 R6 R7: off -5 at pc 100
      for (int code = 0; code < 4; code++) begin
         for (int c = 0; c < 2; c++) begin
            logic exp_t;
            logic [3:0] tg;
            exp_t = code[c];
            tg = 4'(code * 2 + c);
            issue(1'b0, cw(tg, 7'h7B, 2'(code)), {~1'(c), 1'(c)}, 2'(code), 32'd100);
            expect_res("R3", exp_t, exp_t ? 32'd95 : 32'd101, tg, 1'b0);
         end
      end
   endtask

   task automatic t_ext_table();
      // R4 R6: offset 0x100000 at pc 1000
      logic [15:0] tbls [3];
      tbls[0] = 16'h8000; tbls[1] = 16'h6996; tbls[2] = 16'h0200;
      for (int t = 0; t < 3; t++) begin
         for (int idx = 0; idx < 16; idx++) begin
            logic exp_t;
            exp_t = tbls[t][idx];
            issue(1'b1, xw(3'd2, 4'hA, 2'd1, 23'h100000, tbls[t]),
                  2'(idx), 2'(idx >> 2), 32'd1000);
            expect_res("R4", exp_t, exp_t ? 32'd1000 + 32'h100000 : 32'd1001,
                       4'hA, 1'b0);
         end
      end
      // R6 negative long offset, op 1 form
      issue(1'b1, xw(3'd1, 4'h3, 2'd0, 23'h7FFFF0, 16'hFFFF), 2'd0, 2'd0, 32'd1000);
      expect_res("R6", 1'b1, 32'd984, 4'h3, 1'b0);
   endtask

   task automatic t_jump();
      // R5
      issue(1'b0, uw(4'h5, 2'd1, 7'h40), 2'd0, 2'd0, 32'd500);
      expect_res("R5", 1'b1, 32'd436, 4'h5, 1'b0);
      issue(1'b0, uw(4'hF, 2'd0, 7'h3F), 2'd3, 2'd3, 32'd500);
      expect_res("R5", 1'b1, 32'd563, 4'hF, 1'b0);
   endtask

   task automatic t_foreign();
      // R8: link bits set to call, stack must stay empty
      logic [2:0] ops [6];
      ops[0] = 3'd0; ops[1] = 3'd3; ops[2] = 3'd4;
      ops[3] = 3'd5; ops[4] = 3'd6; ops[5] = 3'd7;
      for (int k = 0; k < 6; k++) begin
         issue(1'b0, {32'b0, 7'h05, 2'd2, 4'h7, ops[k]}, 2'd3, 2'd3, 32'd700);
         expect_res("R8", 1'b0, 32'd701, 4'h7, 1'b0);
      end
      issue(1'b1, xw(3'd4, 4'h2, 2'd2, 23'd9, 16'hFFFF), 2'd3, 2'd3, 32'd710);
      expect_res("R8", 1'b0, 32'd711, 4'h2, 1'b0);
      // R8 R11: stack still empty, so a return underflows
      issue(1'b0, uw(4'h1, 2'd3, 7'd4), 2'd0, 2'd0, 32'd720);
      expect_res("R8", 1'b1, 32'd724, 4'h1, 1'b1);
   endtask

   task automatic t_call_ret();
      // R9 R10
      issue(1'b0, uw(4'h1, 2'd2, 7'd5), 2'd0, 2'd0, 32'd10);
      expect_res("R9", 1'b1, 32'd15, 4'h1, 1'b0);
      issue(1'b1, xw(3'd2, 4'h2, 2'd2, 23'd100, 16'hFFFF), 2'd1, 2'd2, 32'd20);
      expect_res("R9", 1'b1, 32'd120, 4'h2, 1'b0);
      issue(1'b1, xw(3'd2, 4'h3, 2'd2, 23'd100, 16'h0000), 2'd1, 2'd2, 32'd30);
      expect_res("R9", 1'b0, 32'd31, 4'h3, 1'b0);
      issue(1'b0, uw(4'h4, 2'd3, 7'd1), 2'd0, 2'd0, 32'd40);
      expect_res("R10", 1'b1, 32'd21, 4'h4, 1'b0);
      issue(1'b1, xw(3'd1, 4'h5, 2'd3, 23'd1, 16'h0001), 2'd0, 2'd0, 32'd50);
      expect_res("R10", 1'b1, 32'd11, 4'h5, 1'b0);
   endtask

   task automatic t_overflow();
      // R11
      for (int k = 1; k <= 4; k++) begin
         issue(1'b0, uw(4'(k), 2'd2, 7'd2), 2'd0, 2'd0, 32'(k * 100));
         expect_res("R11", 1'b1, 32'(k * 100 + 2), 4'(k), 1'b0);
      end
      issue(1'b0, uw(4'h9, 2'd2, 7'd2), 2'd0, 2'd0, 32'd500);
      expect_res("R11", 1'b1, 32'd502, 4'h9, 1'b1);
      for (int k = 4; k >= 1; k--) begin
         issue(1'b0, uw(4'h6, 2'd3, 7'd3), 2'd0, 2'd0, 32'd900);
         expect_res("R11", 1'b1, 32'(k * 100 + 1), 4'h6, 1'b0);
      end
      issue(1'b0, uw(4'h6, 2'd3, 7'd3), 2'd0, 2'd0, 32'd900);
      expect_res("R11", 1'b1, 32'd903, 4'h6, 1'b1);
   endtask

   task automatic t_idle();
      // R2
      issue(1'b0, cw(4'hC, 7'd8, 2'd3), 2'd0, 2'd0, 32'd60);
      expect_res("R2", 1'b1, 32'd68, 4'hC, 1'b0);
      @(negedge clk);
      chk("R2 vld_out low", 64'(vld_out), 0);
      chk("R2 taken held", 64'(taken), 1);
      chk("R2 next_addr held", 64'(next_addr), 68);
      chk("R2 dest_tag held", 64'(dest_tag), 64'hC);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      t_reset();
      t_short_cond();
      t_ext_table();
      t_jump();
      t_foreign();
      t_call_ret();
      t_overflow();
      t_idle();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      #200000;
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule